// File: doc/BRIEF.md
# Biphase-Mark Subframe Transmitter

This block serialises stereo audio for a two-wire balanced digital audio link. A producer hands over one frame at a time: a left and a right 24-bit sample, and for each channel a validity, a user and a channel-status bit. The block assembles two 32-slot subframes per frame, inserts the sync preamble and even parity, and biphase-mark encodes the result onto a complementary pair of line outputs. It runs at one line state per pulse of an external strobe, so a frame takes 128 strobes. It counts frames within a 192-frame block and flags the start of each block on an output pin.

Frames arrive over a valid/ready stream into a single holding register. The producer may raise `frm_valid` at any time and must keep the payload steady until it sees `frm_ready` high at a rising clock edge with `frm_valid` high. While the holding register is full, `frm_ready` stays low and the producer waits. The register is emptied at the first line state of each frame. If it is empty at that moment, a filler frame goes out instead. Two plain controls sit beside the stream: a timing reset that parks the link in its idle state, and a mute that pulls both wires low.

Top module: `bmc_subframe_tx`

## Requirements
- R1: Each subframe has 32 slots. Slots 0-3 hold the preamble. Slots 4-27 hold the sample, with slot 4 as bit 0 and slot 27 as bit 23. Slot 28 is validity, slot 29 is user and slot 30 is channel status. Slot 31 makes the count of ones in slots 4-31 even.
- R2: The first subframe of frame 0 carries preamble B. The first subframe of frames 1-191 carries M. Every second subframe carries W. After frame 191 the count returns to frame 0.
- R3: With a previous line level of 0, the preamble sends the eight states B=11101000, M=11100010 or W=11100100, leftmost first. With a previous level of 1 it sends the bitwise inverse.
- R4: Every data slot starts with the inverse of the previous line level. For a 1 the second state toggles again; for a 0 it repeats the first.
- R5: A frame accepted with `frm_short`=1 sends slots 4-11 of both subframes as 0, whatever the low sample byte holds.
- R6: A frame is taken when `frm_valid` and `frm_ready` are both high at a clock edge. After that `frm_ready` stays low until the frame moves out at the first state of the next frame. The frame being sent does not change while a newer one waits or is presented.
- R7: If no frame is held when a frame starts, that frame sends sample 0 with validity 1 and user and status 0 on both channels.
- R8: `blk_start` rises after the state 2 slots into the second subframe of frame 0 (state index 4). It falls at the same point of frame 32.
- R9: While `timing_rst` is high (and mute low), `line_p`=1, `line_n`=0 and `blk_start`=1. The counters are cleared, so the first strobe after release sends preamble B with a previous level of 0.
- R10: While `mute` is high, `line_p` and `line_n` are both 0 and `blk_start` is 1. Mute clears the counters in the same way as R9.
- R11: Outside mute, `line_n` is the inverse of `line_p`. Outside timing reset and mute, `line_p` changes only in the clock cycle after a `state_tick` pulse.
- R12: After `rst_n` the outputs are `line_p`=0, `line_n`=1, `blk_start`=1 and `frm_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| state_tick | input | 1 | One-cycle strobe, one per line state |
| timing_rst | input | 1 | Park the link idle and clear the counters |
| mute | input | 1 | Drive both wires low and clear the counters |
| frm_valid | input | 1 | Frame on the stream is valid |
| frm_ready | output | 1 | Holding register can take a frame |
| frm_left_smp | input | 24 | Left sample, two's complement |
| frm_left_v | input | 1 | Left validity bit |
| frm_left_u | input | 1 | Left user bit |
| frm_left_c | input | 1 | Left channel-status bit |
| frm_right_smp | input | 24 | Right sample, two's complement |
| frm_right_v | input | 1 | Right validity bit |
| frm_right_u | input | 1 | Right user bit |
| frm_right_c | input | 1 | Right channel-status bit |
| frm_short | input | 1 | Frame carries 16-bit samples |
| line_p | output | 1 | Positive line output |
| line_n | output | 1 | Negative line output |
| blk_start | output | 1 | Block-start flag |

## Verification
The bench decodes no stream. It predicts every line state of every frame from the slot layout and coding rules and compares it with both wires and the block flag. The first two frames are all zeros and all ones: together they show whether the data half-states toggle only for ones, and whether parity flips between the two cases. Later frames use mixed values that differ per channel and per frame, so a swapped channel, a wrong slot order or a stale frame shows up. Dedicated frames exercise the 16-bit mask, the filler frame, a second frame waiting behind a full holding register, and a run over a whole block and back to frame 0 (B preamble, flag fall at frame 32, flag rise again). Mute and timing reset are checked at the pins and then shown to restart the stream from frame 0.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int SMP_W      = 24;
  localparam int SLOT_N     = 32;
  localparam int STATE_N    = 2 * SLOT_N;
  localparam int ST_W       = $clog2(STATE_N);
  localparam int PRE_SLOTS  = 4;
  localparam int PRE_STATES = 2 * PRE_SLOTS;
  localparam int SMP_SLOT0  = PRE_SLOTS;
  localparam int V_SLOT     = SMP_SLOT0 + SMP_W;
  localparam int U_SLOT     = V_SLOT + 1;
  localparam int C_SLOT     = V_SLOT + 2;
  localparam int P_SLOT     = V_SLOT + 3;
  localparam int SHORT_ZERO = 8;

  typedef struct packed {
    logic [SMP_W-1:0] smp;
    logic             v;
    logic             u;
    logic             c;
  } chan_t;

  typedef enum logic [1:0] {PRE_B = 2'd0, PRE_M = 2'd1, PRE_W = 2'd2} pre_e;

  // Preamble state patterns for a previous line level of 0, first state in bit 7.
  function automatic logic [7:0] pre_bits(pre_e k);
    case (k)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmc_tx_timing.sv
module bmc_tx_timing
  import bmc_tx_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int FLAG_FRAMES = 32,
  parameter int FLAG_DELAY  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            tick,
  output logic [ST_W-1:0] st,
  output logic            sub,
  output logic            frame_zero,
  output logic            blk_q
);
  localparam int FW = $clog2(FRAMES);

  logic [FW-1:0] frame;
  logic          last_st;
  logic          flag_pt;

  assign last_st    = (st == ST_W'(STATE_N - 1));
  assign frame_zero = (frame == '0);
  assign flag_pt    = sub && (st == ST_W'(FLAG_DELAY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= '0;
      sub   <= 1'b0;
      frame <= '0;
    end else if (hold) begin
      st    <= '0;
      sub   <= 1'b0;
      frame <= '0;
    end else if (tick) begin
      st <= st + 1'b1;
      if (last_st) begin
        sub <= ~sub;
        if (sub) frame <= (frame == FW'(FRAMES - 1)) ? '0 : frame + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    blk_q <= 1'b1;
    else if (hold)                 blk_q <= 1'b1;
    else if (tick && flag_pt) begin
      if (frame_zero)                       blk_q <= 1'b1;
      else if (frame == FW'(FLAG_FRAMES))   blk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bmc_tx_payload.sv
module bmc_tx_payload
  import bmc_tx_pkg::*;
(
  input  chan_t             ch,
  input  logic              short_w,
  output logic [SLOT_N-1:0] word
);
  assign word[PRE_SLOTS-1:0] = '0;

  for (genvar i = 0; i < SMP_W; i++) begin : g_smp
    if (i < SHORT_ZERO) begin : g_mask
      assign word[SMP_SLOT0+i] = ch.smp[i] & ~short_w;
    end else begin : g_pass
      assign word[SMP_SLOT0+i] = ch.smp[i];
    end
  end

  assign word[V_SLOT] = ch.v;
  assign word[U_SLOT] = ch.u;
  assign word[C_SLOT] = ch.c;
  assign word[P_SLOT] = ^word[C_SLOT:SMP_SLOT0];
endmodule

// File: rtl/bmc_tx_encoder.sv
module bmc_tx_encoder
  import bmc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              tick,
  input  logic [ST_W-1:0]   st,
  input  pre_e              kind,
  input  logic [SLOT_N-1:0] word,
  output logic              lvl
);
  logic            pre_pol;
  logic            pol;
  logic            nxt;
  logic [7:0]      pat;
  logic [ST_W-2:0] slot;

  always_comb begin
    slot = st[ST_W-1:1];
    pat  = pre_bits(kind);
    pol  = (st == '0) ? lvl : pre_pol;
    if (st < ST_W'(PRE_STATES))   nxt = pat[3'd7 - st[2:0]] ^ pol;
    else if (!st[0])              nxt = ~lvl;
    else                          nxt = word[slot] ? ~lvl : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= 1'b0;
      pre_pol <= 1'b0;
    end else if (hold) begin
      lvl     <= 1'b0;
      pre_pol <= 1'b0;
    end else if (tick) begin
      lvl <= nxt;
      if (st == '0) pre_pol <= lvl;
    end
  end
endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
  import bmc_tx_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int FLAG_FRAMES = 32,
  parameter int FLAG_DELAY  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             state_tick,
  input  logic             timing_rst,
  input  logic             mute,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [SMP_W-1:0] frm_left_smp,
  input  logic             frm_left_v,
  input  logic             frm_left_u,
  input  logic             frm_left_c,
  input  logic [SMP_W-1:0] frm_right_smp,
  input  logic             frm_right_v,
  input  logic             frm_right_u,
  input  logic             frm_right_c,
  input  logic             frm_short,
  output logic             line_p,
  output logic             line_n,
  output logic             blk_start
);
  localparam chan_t FILL_CH = '{smp: '0, v: 1'b1, u: 1'b0, c: 1'b0};

  logic              hold_i;
  logic [ST_W-1:0]   st;
  logic              sub;
  logic              frame_zero;
  logic              blk_q;
  logic              lvl;
  logic              accept;
  logic              load;
  logic              hold_full;
  chan_t             in_l, in_r, hold_l, hold_r, cur_l, cur_r, sel_ch;
  logic              hold_s, cur_s;
  pre_e              kind;
  logic [SLOT_N-1:0] word;

  assign hold_i    = timing_rst | mute;
  assign in_l      = '{smp: frm_left_smp,  v: frm_left_v,  u: frm_left_u,  c: frm_left_c};
  assign in_r      = '{smp: frm_right_smp, v: frm_right_v, u: frm_right_u, c: frm_right_c};
  assign frm_ready = ~hold_full;
  assign accept    = frm_valid & ~hold_full;
  assign load      = state_tick & ~hold_i & (st == '0) & ~sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      hold_s    <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_l    <= in_l;
      hold_r    <= in_r;
      hold_s    <= frm_short;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l <= FILL_CH;
      cur_r <= FILL_CH;
      cur_s <= 1'b0;
    end else if (load) begin
      cur_l <= hold_full ? hold_l : FILL_CH;
      cur_r <= hold_full ? hold_r : FILL_CH;
      cur_s <= hold_full & hold_s;
    end
  end

  assign sel_ch = sub ? cur_r : cur_l;
  assign kind   = sub ? PRE_W : (frame_zero ? PRE_B : PRE_M);

  bmc_tx_timing #(
    .FRAMES(FRAMES), .FLAG_FRAMES(FLAG_FRAMES), .FLAG_DELAY(FLAG_DELAY)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hold(hold_i), .tick(state_tick),
    .st(st), .sub(sub), .frame_zero(frame_zero), .blk_q(blk_q)
  );

  bmc_tx_payload u_payload (.ch(sel_ch), .short_w(cur_s), .word(word));

  bmc_tx_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .hold(hold_i), .tick(state_tick),
    .st(st), .kind(kind), .word(word), .lvl(lvl)
  );

  assign line_p    = ~mute & (timing_rst | lvl);
  assign line_n    = ~mute & ~timing_rst & ~lvl;
  assign blk_start = blk_q | hold_i;
endmodule

// File: rtl/bmc_subframe_tx_chk.sv
module bmc_subframe_tx_chk
  import bmc_tx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            state_tick,
  input logic            timing_rst,
  input logic            mute,
  input logic            frm_valid,
  input logic            frm_ready,
  input logic            line_p,
  input logic            line_n,
  input logic            blk_start,
  input logic [ST_W-1:0] st,
  input logic            sub,
  input logic            frame_zero
);
  logic run;
  assign run = ~timing_rst & ~mute;

  assert_mute_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> (!line_p && !line_n));

  assert_trst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_rst && !mute) |-> (line_p && !line_n && blk_start));

  assert_complement_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |-> (line_n == !line_p));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !state_tick) |=> (mute || timing_rst || $stable(line_p)));

  assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> !frm_ready);

  assert_first_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state_tick && st >= ST_W'(PRE_STATES) && !st[0])
      |=> (mute || timing_rst || line_p != $past(line_p)));

  assert_blk_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state_tick && sub && frame_zero && st == ST_W'(4)) |=> blk_start);
endmodule

bind bmc_subframe_tx bmc_subframe_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_tick(state_tick), .timing_rst(timing_rst),
  .mute(mute), .frm_valid(frm_valid), .frm_ready(frm_ready), .line_p(line_p),
  .line_n(line_n), .blk_start(blk_start), .st(st), .sub(sub),
  .frame_zero(frame_zero)
);

// File: tb/tb_bmc_subframe_tx.sv
module tb_bmc_subframe_tx;
  import bmc_tx_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tick, tick_en, timing_rst, mute, frm_valid, frm_ready, frm_short;
  logic [23:0] l_smp, r_smp;
  logic l_v, l_u, l_c, r_v, r_u, r_c;
  logic line_p, line_n, blk_start;

  int errs = 0, checks = 0, fidx = 0;
  logic exp_lvl, blk_exp;
  bit done = 0;

  bmc_subframe_tx dut (
    .clk(clk), .rst_n(rst_n), .state_tick(tick), .timing_rst(timing_rst), .mute(mute),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_left_smp(l_smp), .frm_left_v(l_v), .frm_left_u(l_u), .frm_left_c(l_c),
    .frm_right_smp(r_smp), .frm_right_v(r_v), .frm_right_u(r_u), .frm_right_c(r_c),
    .frm_short(frm_short), .line_p(line_p), .line_n(line_n), .blk_start(blk_start)
  );

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = tick_en ? ~tick : 1'b0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic want, input string what);
    checks++;
    if (act !== want) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b (frame %0d)", tag, what, act, want, fidx);
    end
  endtask

  function automatic chan_t gen_ch(int k, bit right);
    chan_t c;
    if (k == 0) c = '0;
    else if (k == 1) c = '{smp: 24'hFFFFFF, v: 1'b1, u: 1'b1, c: 1'b1};
    else begin
      c.smp = 24'(k * 40503) ^ (right ? 24'hC3C3C3 : 24'h1E1E1E);
      c.v   = k[0] ^ right;
      c.u   = k[1];
      c.c   = k[2] ^ k[3];
    end
    return c;
  endfunction

  function automatic logic [31:0] exp_word(chan_t ch, logic sh);
    logic [31:0] w = '0;
    w[27:4] = ch.smp;
    if (sh) w[11:4] = '0;
    w[28] = ch.v; w[29] = ch.u; w[30] = ch.c;
    w[31] = ^w[30:4];
    return w;
  endfunction

  function automatic logic [7:0] exp_pat(int kind);
    if (kind == 0) return 8'b11101000;
    if (kind == 1) return 8'b11100010;
    return 8'b11100100;
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (tick !== 1'b1);
    #1;
  endtask

  task automatic push(input int k, input logic sh);
    chan_t a = gen_ch(k, 1'b0);
    chan_t b = gen_ch(k, 1'b1);
    @(negedge clk);
    {l_smp, l_v, l_u, l_c} = a;
    {r_smp, r_v, r_u, r_c} = b;
    frm_short = sh;
    frm_valid = 1'b1;
    while (!frm_ready) @(negedge clk);
    @(posedge clk);
    #1 frm_valid = 1'b0;
  endtask

  task automatic check_sub(input int kind, input logic [31:0] w, input logic sh,
                           input logic ur, input int s);
    logic pol, e;
    int slot;
    string tag;
    pol = exp_lvl;
    for (int k = 0; k < 64; k++) begin
      slot = k / 2;
      if (k < 8) begin e = exp_pat(kind)[7-k] ^ pol; tag = "R2/R3"; end
      else begin
        e = (k % 2 == 0) ? ~exp_lvl : (w[slot] ? ~exp_lvl : exp_lvl);
        if (slot == 31) tag = "R1";
        else if (sh && slot < 12) tag = "R5";
        else if (ur) tag = "R7";
        else tag = "R4";
      end
      wait_tick();
      chk(tag, line_p, e, "line_p");
      chk("R11", line_n, ~e, "line_n");
      if (s == 1 && k == 4) begin
        if (fidx == 0) blk_exp = 1'b1;
        else if (fidx == 32) blk_exp = 1'b0;
      end
      chk("R8", blk_start, blk_exp, "blk_start");
      exp_lvl = e;
    end
  endtask

  task automatic check_frame(input int k, input logic sh, input logic ur);
    chan_t fill = '{smp: '0, v: 1'b1, u: 1'b0, c: 1'b0};
    chan_t a = ur ? fill : gen_ch(k, 1'b0);
    chan_t b = ur ? fill : gen_ch(k, 1'b1);
    logic s = sh & ~ur;
    check_sub((fidx == 0) ? 0 : 1, exp_word(a, s), s, ur, 0);
    check_sub(2, exp_word(b, s), s, ur, 1);
    fidx = (fidx == 191) ? 0 : fidx + 1;
  endtask

  task automatic test_reset();
    chk("R12", line_p, 1'b0, "line_p");
    chk("R12", line_n, 1'b1, "line_n");
    chk("R12", blk_start, 1'b1, "blk_start");
    chk("R12", frm_ready, 1'b1, "frm_ready");
  endtask

  task automatic test_mute_idle();
    @(negedge clk) mute = 1'b1; tick_en = 1'b1;
    #1;
    chk("R10", line_p, 1'b0, "line_p"); chk("R10", line_n, 1'b0, "line_n");
    chk("R10", blk_start, 1'b1, "blk_start");
    repeat (20) @(posedge clk);
    #1;
    chk("R10", line_p, 1'b0, "line_p held"); chk("R10", line_n, 1'b0, "line_n held");
  endtask

  task automatic test_timing_idle();
    @(negedge clk) timing_rst = 1'b1; mute = 1'b0;
    #1;
    chk("R9", line_p, 1'b1, "line_p"); chk("R9", line_n, 1'b0, "line_n");
    chk("R9", blk_start, 1'b1, "blk_start");
    repeat (20) @(posedge clk);
    #1;
    chk("R9", line_p, 1'b1, "line_p held"); chk("R9", line_n, 1'b0, "line_n held");
    push(0, 1'b0);
    chk("R6", frm_ready, 1'b0, "frm_ready after accept");
    @(negedge clk) timing_rst = 1'b0;
    exp_lvl = 1'b0; blk_exp = 1'b1; fidx = 0;
  endtask

  task automatic test_stream();
    for (int k = 0; k < 194; k++) begin
      if (k == 7) begin
        push(7, 1'b0);
        chk("R6", frm_ready, 1'b0, "frm_ready while full");
        fork
          check_frame(7, 1'b0, 1'b0);
          push(8, 1'b0);
        join
      end else begin
        if (k != 0 && k != 5 && k != 8) push(k, k == 3);
        check_frame(k, k == 3, k == 5);
      end
    end
  endtask

  task automatic test_mute_restart();
    @(negedge clk) mute = 1'b1;
    #1;
    chk("R10", line_p, 1'b0, "line_p"); chk("R10", line_n, 1'b0, "line_n");
    chk("R10", blk_start, 1'b1, "blk_start");
    push(200, 1'b0);
    @(negedge clk) mute = 1'b0;
    exp_lvl = 1'b0; blk_exp = 1'b1; fidx = 0;
    check_frame(200, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; timing_rst = 1'b0; mute = 1'b0;
    frm_valid = 1'b0; frm_short = 1'b0;
    {l_smp, l_v, l_u, l_c, r_smp, r_v, r_u, r_c} = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;
    test_reset();
    test_mute_idle();
    test_timing_idle();
    test_stream();
    test_mute_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule